// File: doc/BRIEF.md
# Far Return Code-Segment Validator

This block decides whether a far return may proceed. It receives the return code-segment selector and the fields of the descriptor that selector points to, along with the descriptor-table limit, the current privilege level, a long-mode flag and a flag that says whether the descriptor address is canonical. It runs an ordered chain of checks. The first check that fails sets the fault class and the error code. If every check passes, the block asserts a go signal and states whether the return crosses to an outer privilege level or stays at the current one.

The block is purely combinational. It sits between the stage that fetches the descriptor and the stage that pops the stack. Descriptor fetch, stack pops and stack-segment checks are done elsewhere.

Top module: `far_ret_cs_validator`

## Requirements
- R1: The selector layout is index in bits [15:3], table indicator in bit 2 and RPL in bits [1:0]. A selector whose index and table indicator are both zero is null, whatever its RPL. A null selector gives fault_kind 1 (general protection) with error code 0.
- R2: The descriptor occupies bytes index*8 to index*8+7. If index*8+7 is greater than the table limit, the result is fault_kind 1 with the selector as the error code.
- R3: When long_mode_i is 1 and desc_canon_i is 0, the result is fault_kind 1 with the selector as the error code. When long_mode_i is 0, desc_canon_i has no effect.
- R4: A descriptor that is not a code segment (desc_is_code_i = 0) gives fault_kind 1 with the selector as the error code.
- R5: When long_mode_i is 1 and both desc_long_i and desc_dflt_i are set, the result is fault_kind 1 with the selector as the error code. When long_mode_i is 0, this combination has no effect.
- R6: An RPL lower than cpl_i gives fault_kind 1 with the selector as the error code.
- R7: A conforming descriptor whose DPL is greater than the RPL gives fault_kind 1 with the selector as the error code.
- R8: A non-conforming descriptor whose DPL differs from the RPL gives fault_kind 1 with the selector as the error code.
- R9: A descriptor that is not present gives fault_kind 2 (segment not present) with the selector as the error code. This fault is reported only when every general-protection check passes.
- R10: Only the first failing check is reported. The order is: null, limit, canonical, code type, long/default bits, RPL below CPL, conforming DPL, non-conforming DPL, present.
- R11: With no fault, fault_kind is 0, go_o is 1, the error code is 0, and outer_o is 1 exactly when RPL is greater than cpl_i. With a fault, go_o and outer_o are both 0.
- R12: A selector-based error code is the selector with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 16 | Popped return code-segment selector |
| tbl_limit_i | input | 16 | Descriptor-table limit in bytes |
| desc_canon_i | input | 1 | Descriptor address is canonical |
| desc_is_code_i | input | 1 | Descriptor describes a code segment |
| desc_conform_i | input | 1 | Code segment is conforming |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| desc_present_i | input | 1 | Descriptor present bit |
| desc_long_i | input | 1 | Descriptor 64-bit code bit |
| desc_dflt_i | input | 1 | Descriptor default-size bit |
| cpl_i | input | 2 | Current privilege level |
| long_mode_i | input | 1 | Processor is in long mode |
| fault_kind_o | output | 2 | 0 none, 1 general protection, 2 not present |
| fault_code_o | output | 16 | Error code of the reported fault |
| go_o | output | 1 | All checks passed |
| outer_o | output | 1 | Return goes to an outer privilege level |

## Verification
The bench sweeps every combination of RPL, CPL, DPL, the descriptor flags and the mode flags against four selectors: null, null index with table bit set, the last descriptor inside the limit, and the first descriptor past it. The limit-edge pair catches an off-by-one in the limit compare; such a design would either fault on a valid last entry or accept one byte past the table. Vectors that break several rules at once expose a wrong priority, which would show up as a not-present fault where a protection fault is due, or as a selector code where the null check should give zero. The long-mode-only checks are swept with the mode flag clear, so a design that applies them in legacy mode would fault on legal returns. A selector with only the table bit set catches a null test that ignores that bit.

// File: rtl/far_ret_pkg.sv
package far_ret_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_GP   = 2'd1,
      FK_NP   = 2'd2
   } fault_kind_t;

   // check positions, lowest index has highest priority
   localparam int CHK_NULL     = 0;
   localparam int CHK_LIMIT    = 1;
   localparam int CHK_CANON    = 2;
   localparam int CHK_NOTCODE  = 3;
   localparam int CHK_LD       = 4;
   localparam int CHK_RPL_LOW  = 5;
   localparam int CHK_CONF     = 6;
   localparam int CHK_NONCONF  = 7;
   localparam int CHK_ABSENT   = 8;
   localparam int NUM_CHECKS   = 9;

   // checks reporting a zero error code and checks reporting not-present
   localparam logic [NUM_CHECKS-1:0] ZERO_CODE_MASK = 9'b0_0000_0001;
   localparam logic [NUM_CHECKS-1:0] NP_MASK        = 9'b1_0000_0000;

endpackage

// File: rtl/frv_sel_fields.sv
module frv_sel_fields #(
   parameter int SEL_W      = 16,
   parameter int LIMIT_W    = 16,
   parameter int DESC_SHIFT = 3,
   parameter int PRIV_W     = 2
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [LIMIT_W-1:0] limit,
   output logic [PRIV_W-1:0]  rpl,
   output logic               is_null,
   output logic               beyond_limit,
   output logic [SEL_W-1:0]   sel_code
);
   localparam int IDX_W   = SEL_W - PRIV_W - 1;
   localparam int END_W   = IDX_W + DESC_SHIFT;
   localparam int CMP_W   = (END_W > LIMIT_W) ? END_W : LIMIT_W;

   generate
      if (SEL_W < PRIV_W + 2) begin : g_bad_sel
         $error("selector too narrow for index, table bit and RPL");
      end
      if (DESC_SHIFT < 1) begin : g_bad_shift
         $error("descriptor size must be at least two bytes");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             tbl_bit;
   logic [END_W-1:0] end_off;
   logic [CMP_W-1:0] end_cmp;
   logic [CMP_W-1:0] lim_cmp;

   always_comb begin
      rpl      = sel[PRIV_W-1:0];
      tbl_bit  = sel[PRIV_W];
      idx      = sel[SEL_W-1:PRIV_W+1];
      is_null  = (idx == '0) && !tbl_bit;
      // last byte of the selected entry
      end_off  = {idx, {DESC_SHIFT{1'b1}}};
      end_cmp  = CMP_W'(end_off);
      lim_cmp  = CMP_W'(limit);
      beyond_limit = end_cmp > lim_cmp;
      sel_code = {sel[SEL_W-1:PRIV_W], {PRIV_W{1'b0}}};
   end

endmodule

// File: rtl/frv_desc_rules.sv
module frv_desc_rules #(
   parameter int PRIV_W = 2
) (
   input  logic [PRIV_W-1:0] rpl,
   input  logic [PRIV_W-1:0] cpl,
   input  logic [PRIV_W-1:0] dpl,
   input  logic              is_code,
   input  logic              conform,
   input  logic              long_bit,
   input  logic              dflt_bit,
   input  logic              canon,
   input  logic              long_mode,
   output logic              f_canon,
   output logic              f_notcode,
   output logic              f_ld,
   output logic              f_rpl_low,
   output logic              f_conf,
   output logic              f_nonconf
);
   always_comb begin
      f_canon   = long_mode && !canon;
      f_notcode = !is_code;
      f_ld      = long_mode && long_bit && dflt_bit;
      f_rpl_low = rpl < cpl;
      f_conf    = conform && (dpl > rpl);
      f_nonconf = !conform && (dpl != rpl);
   end
endmodule

// File: rtl/frv_first_fail.sv
module frv_first_fail #(
   parameter int N   = 9,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  fail,
   output logic          hit,
   output logic [IW-1:0] first
);
   always_comb begin
      hit   = 1'b0;
      first = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (fail[i]) begin
            hit   = 1'b1;
            first = IW'(i);
         end
      end
   end
endmodule

// File: rtl/far_ret_cs_validator.sv
module far_ret_cs_validator
   import far_ret_pkg::*;
#(
   parameter int SEL_W      = 16,
   parameter int LIMIT_W    = 16,
   parameter int DESC_SHIFT = 3,
   parameter int PRIV_W     = 2
) (
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [LIMIT_W-1:0] tbl_limit_i,
   input  logic               desc_canon_i,
   input  logic               desc_is_code_i,
   input  logic               desc_conform_i,
   input  logic [PRIV_W-1:0]  desc_dpl_i,
   input  logic               desc_present_i,
   input  logic               desc_long_i,
   input  logic               desc_dflt_i,
   input  logic [PRIV_W-1:0]  cpl_i,
   input  logic               long_mode_i,
   output logic [1:0]         fault_kind_o,
   output logic [SEL_W-1:0]   fault_code_o,
   output logic               go_o,
   output logic               outer_o
);
   localparam int IW = $clog2(NUM_CHECKS);

   logic [PRIV_W-1:0]     rpl;
   logic                  is_null;
   logic                  beyond;
   logic [SEL_W-1:0]      sel_code;
   logic                  f_canon, f_notcode, f_ld, f_rpl_low, f_conf, f_nonconf;
   logic [NUM_CHECKS-1:0] fail_vec;
   logic                  any_fail;
   logic [IW-1:0]         first;

   frv_sel_fields #(
      .SEL_W(SEL_W), .LIMIT_W(LIMIT_W), .DESC_SHIFT(DESC_SHIFT), .PRIV_W(PRIV_W)
   ) u_sel (
      .sel          (sel_i),
      .limit        (tbl_limit_i),
      .rpl          (rpl),
      .is_null      (is_null),
      .beyond_limit (beyond),
      .sel_code     (sel_code)
   );

   frv_desc_rules #(.PRIV_W(PRIV_W)) u_rules (
      .rpl       (rpl),
      .cpl       (cpl_i),
      .dpl       (desc_dpl_i),
      .is_code   (desc_is_code_i),
      .conform   (desc_conform_i),
      .long_bit  (desc_long_i),
      .dflt_bit  (desc_dflt_i),
      .canon     (desc_canon_i),
      .long_mode (long_mode_i),
      .f_canon   (f_canon),
      .f_notcode (f_notcode),
      .f_ld      (f_ld),
      .f_rpl_low (f_rpl_low),
      .f_conf    (f_conf),
      .f_nonconf (f_nonconf)
   );

   always_comb begin
      fail_vec              = '0;
      fail_vec[CHK_NULL]    = is_null;
      fail_vec[CHK_LIMIT]   = beyond;
      fail_vec[CHK_CANON]   = f_canon;
      fail_vec[CHK_NOTCODE] = f_notcode;
      fail_vec[CHK_LD]      = f_ld;
      fail_vec[CHK_RPL_LOW] = f_rpl_low;
      fail_vec[CHK_CONF]    = f_conf;
      fail_vec[CHK_NONCONF] = f_nonconf;
      fail_vec[CHK_ABSENT]  = !desc_present_i;
   end

   frv_first_fail #(.N(NUM_CHECKS)) u_prio (
      .fail  (fail_vec),
      .hit   (any_fail),
      .first (first)
   );

   // per-check fault class and error code tables
   logic [1:0]       kind_tab [NUM_CHECKS];
   logic [SEL_W-1:0] code_tab [NUM_CHECKS];

   generate
      for (genvar c = 0; c < NUM_CHECKS; c++) begin : g_chk
         if (NP_MASK[c]) begin : g_np
            assign kind_tab[c] = FK_NP;
         end else begin : g_gp
            assign kind_tab[c] = FK_GP;
         end
         if (ZERO_CODE_MASK[c]) begin : g_zero
            assign code_tab[c] = '0;
         end else begin : g_selc
            assign code_tab[c] = sel_code;
         end
      end
   endgenerate

   always_comb begin
      if (any_fail) begin
         fault_kind_o = kind_tab[first];
         fault_code_o = code_tab[first];
         go_o         = 1'b0;
         outer_o      = 1'b0;
      end else begin
         fault_kind_o = FK_NONE;
         fault_code_o = '0;
         go_o         = 1'b1;
         outer_o      = rpl > cpl_i;
      end
   end

endmodule

// File: rtl/far_ret_cs_checker.sv
module far_ret_cs_checker #(
   parameter int SEL_W  = 16,
   parameter int PRIV_W = 2
) (
   input logic [SEL_W-1:0]  sel_i,
   input logic [PRIV_W-1:0] cpl_i,
   input logic              desc_is_code_i,
   input logic              desc_present_i,
   input logic              desc_long_i,
   input logic              desc_dflt_i,
   input logic              long_mode_i,
   input logic [1:0]        fault_kind_o,
   input logic [SEL_W-1:0]  fault_code_o,
   input logic              go_o,
   input logic              outer_o
);
   always_comb begin
      if (sel_i[SEL_W-1:PRIV_W] == '0) begin
         a_r1_null_zero_code: assert (fault_kind_o == 2'd1 && fault_code_o == '0)
            else $error("null selector not reported as GP with zero code");
      end
      if (go_o) begin
         a_r4_go_needs_code: assert (desc_is_code_i)
            else $error("go with non-code descriptor");
         a_r5_go_no_ld: assert (!(long_mode_i && desc_long_i && desc_dflt_i))
            else $error("go with L and D set in long mode");
         a_r6_go_rpl_ge_cpl: assert (sel_i[PRIV_W-1:0] >= cpl_i)
            else $error("go with RPL below CPL");
         a_r9_go_present: assert (desc_present_i)
            else $error("go with absent descriptor");
         a_r11_outer_match: assert (outer_o == (sel_i[PRIV_W-1:0] > cpl_i))
            else $error("outer path disagrees with privilege levels");
      end
      if (fault_kind_o == 2'd2) begin
         a_r9_np_absent: assert (!desc_present_i)
            else $error("not-present fault on present descriptor");
      end
      a_r11_go_excl_fault: assert (go_o == (fault_kind_o == 2'd0))
         else $error("go and fault disagree");
      a_r11_outer_needs_go: assert (!outer_o || go_o)
         else $error("outer asserted without go");
      a_r12_low_bits_clear: assert (fault_code_o[PRIV_W-1:0] == '0)
         else $error("error code low bits not cleared");
   end
endmodule

bind far_ret_cs_validator far_ret_cs_checker #(.SEL_W(SEL_W), .PRIV_W(PRIV_W)) u_chk (
   .sel_i          (sel_i),
   .cpl_i          (cpl_i),
   .desc_is_code_i (desc_is_code_i),
   .desc_present_i (desc_present_i),
   .desc_long_i    (desc_long_i),
   .desc_dflt_i    (desc_dflt_i),
   .long_mode_i    (long_mode_i),
   .fault_kind_o   (fault_kind_o),
   .fault_code_o   (fault_code_o),
   .go_o           (go_o),
   .outer_o        (outer_o)
);

// File: tb/far_ret_cs_validator_tb_top.sv
module far_ret_cs_validator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [15:0] sel_i;
   logic [15:0] tbl_limit_i;
   logic        desc_canon_i, desc_is_code_i, desc_conform_i;
   logic [1:0]  desc_dpl_i;
   logic        desc_present_i, desc_long_i, desc_dflt_i;
   logic [1:0]  cpl_i;
   logic        long_mode_i;
   logic [1:0]  fault_kind_o;
   logic [15:0] fault_code_o;
   logic        go_o, outer_o;

   far_ret_cs_validator dut_i (
      .sel_i(sel_i), .tbl_limit_i(tbl_limit_i), .desc_canon_i(desc_canon_i),
      .desc_is_code_i(desc_is_code_i), .desc_conform_i(desc_conform_i),
      .desc_dpl_i(desc_dpl_i), .desc_present_i(desc_present_i),
      .desc_long_i(desc_long_i), .desc_dflt_i(desc_dflt_i), .cpl_i(cpl_i),
      .long_mode_i(long_mode_i), .fault_kind_o(fault_kind_o),
      .fault_code_o(fault_code_o), .go_o(go_o), .outer_o(outer_o)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles > WATCHDOG) begin
         n_checks = n_checks + 1;
         n_fail   = n_fail + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   // independent model of the ordered rule chain
   task automatic model(output logic [1:0] kind, output logic [15:0] code,
                        output logic go, output logic outer, output string tag);
      logic [1:0]  rpl;
      int          idx;
      logic [15:0] sc;
      rpl  = sel_i[1:0];
      idx  = int'(sel_i[15:3]);
      sc   = sel_i & 16'hFFFC;
      kind = 2'd1; code = sc; go = 0; outer = 0;
      if (idx == 0 && sel_i[2] == 1'b0) begin code = 16'h0; tag = "R1"; end
      else if (idx * 8 + 7 > int'(tbl_limit_i)) tag = "R2";
      else if (long_mode_i && !desc_canon_i) tag = "R3";
      else if (!desc_is_code_i) tag = "R4";
      else if (long_mode_i && desc_long_i && desc_dflt_i) tag = "R5";
      else if (rpl < cpl_i) tag = "R6";
      else if (desc_conform_i && desc_dpl_i > rpl) tag = "R7";
      else if (!desc_conform_i && desc_dpl_i != rpl) tag = "R8";
      else if (!desc_present_i) begin kind = 2'd2; tag = "R9"; end
      else begin
         kind = 2'd0; code = 16'h0; go = 1; outer = rpl > cpl_i; tag = "R11";
      end
   endtask

   task automatic compare(input int nviol);
      logic [1:0]  ek;
      logic [15:0] ec;
      logic        eg, eo;
      string       tag;
      model(ek, ec, eg, eo, tag);
      n_checks = n_checks + 1;
      if (fault_kind_o !== ek || fault_code_o !== ec || go_o !== eg || outer_o !== eo) begin
         n_fail = n_fail + 1;
         $display("FAIL %s%s sel=%h cpl=%0d: actual kind=%0d code=%h go=%b outer=%b expected kind=%0d code=%h go=%b outer=%b",
                  tag, (nviol > 1) ? "/R10" : "", sel_i, cpl_i,
                  fault_kind_o, fault_code_o, go_o, outer_o, ek, ec, eg, eo);
      end
      // R12: low two error-code bits always clear
      n_checks = n_checks + 1;
      if (fault_code_o[1:0] !== 2'b00) begin
         n_fail = n_fail + 1;
         $display("FAIL R12: actual low bits %b expected 00", fault_code_o[1:0]);
      end
   endtask

   initial begin
      sel_i = '0; tbl_limit_i = 16'h0027; desc_canon_i = 1; desc_is_code_i = 1;
      desc_conform_i = 0; desc_dpl_i = 0; desc_present_i = 1; desc_long_i = 0;
      desc_dflt_i = 0; cpl_i = 0; long_mode_i = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset-state check: all-zero selector is null (R1)
      n_checks = n_checks + 1;
      if (fault_kind_o !== 2'd1 || fault_code_o !== 16'h0 || go_o !== 1'b0) begin
         n_fail = n_fail + 1;
         $display("FAIL R1 initial: actual kind=%0d code=%h go=%b expected kind=1 code=0000 go=0",
                  fault_kind_o, fault_code_o, go_o);
      end
      // limit 0x27 holds entries 0..4; index 4 is the last fit, 5 the first miss
      for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
      for (int d = 0; d < 4; d++)
      for (int f = 0; f < 128; f++) begin
         int nv;
         @(posedge clk);
         case (s)
            0: sel_i = {13'd0, 1'b0, 2'(r)};
            1: sel_i = {13'd0, 1'b1, 2'(r)};
            2: sel_i = {13'd4, 1'b0, 2'(r)};
            default: sel_i = {13'd5, 1'b1, 2'(r)};
         endcase
         cpl_i          = 2'(c);
         desc_dpl_i     = 2'(d);
         desc_conform_i = f[0];
         desc_is_code_i = f[1];
         desc_present_i = f[2];
         desc_long_i    = f[3];
         desc_dflt_i    = f[4];
         long_mode_i    = f[5];
         desc_canon_i   = f[6];
         nv = int'(s == 0) + int'(s == 3) + int'(f[5] && !f[6]) + int'(!f[1])
            + int'(f[5] && f[3] && f[4]) + int'(r < c)
            + int'(f[0] ? (d > r) : (d != r)) + int'(!f[2]);
         @(negedge clk);
         compare(nv);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule